// File: doc/BRIEF.md
# Sensorless Commutation Phase-Lock Loop

This block keeps six-step commutation of a three-phase motor in step with the rotor, using only the phase voltages. Once per PWM period the block receives a strobe with one converted sample for each motor terminal. It averages the three samples to form a virtual star point, so the winding can be wye or delta. It then takes the terminal left floating by the present commutation step and subtracts the star point from it. The sign of that difference is corrected for the step, so that a late or early rotor always pushes the loop the same way.

A proportional-plus-integral filter turns the corrected error into a frequency word. A phase accumulator adds that word every clock. Each carry out of the accumulator is a one-cycle step pulse that advances the commutation state machine, and the accumulator's top bit is a square-wave tachometer.

A mode input chooses between three phases of operation. In align, the machine holds the rest step (R) and the filter and accumulator are cleared. In ramp, the error is ignored and each strobe raises the frequency by a fixed step, which gives an open-loop spin-up. In run, the loop is closed. The state machine moves through R (rest), then A, B, C, D, E, F, and from F wraps back to A. Its transitions are: ALIGN_HOLD, any state to R while in align; STEP_FIRST, R to A on a step pulse; STEP_NEXT, each state to its successor on a step pulse; WRAP, F to A on a step pulse.

Top module: `bemf_pll`

## Requirements
- R1: While rst_n is low, comm_state is 0 (R), freq_word is 0, step_pulse is 0 and tach is 0.
- R2: mode encodes 1 as ramp and 2 as run. Values 0 and 3 both mean align. After any clock edge taken in align, comm_state is 0, freq_word is 0, tach is 0 and step_pulse is 0, whatever the samples and the strobe carry.
- R3: In ramp, each sample_stb raises freq_word by RAMP_STEP, saturating at the maximum word. The phase samples have no effect.
- R4: The star point is floor((ph_a + ph_b + ph_c) / 3). The raw error is the floating-phase sample minus the star point.
- R5: comm_state encodes R=0, A=1, B=2, C=3, D=4, E=5, F=6. The floating phase is ph_b in A and D, ph_a in B and E, and ph_c in C and F.
- R6: The raw error is used as is in A, C and E, and negated in B, D and F.
- R7: In run, a sample_stb updates the integrator to I' = sat(I + e*2^KI_SH) and sets freq_word = sat(I' + e*2^KP_SH). Here e is the corrected error. freq_word shows the new value from the clock edge that samples the strobe.
- R8: The integrator and freq_word both saturate at 0 and at 2^FREQ_W - 1.
- R9: Outside align, an ACC_W-bit accumulator adds freq_word every clock. step_pulse is high for exactly one cycle per carry out, so the step rate is freq_word / 2^ACC_W per clock. FREQ_W must be smaller than ACC_W.
- R10: In the clock after a step_pulse, comm_state advances R to A, A to B, and so on through F, with F wrapping to A. Without a step_pulse, comm_state holds.
- R11: tach is the accumulator's most significant bit. At a constant word that divides 2^ACC_W, tach is high for exactly half the time.
- R12: Outside align, freq_word does not change in a cycle without sample_stb.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | 0/3 align, 1 ramp, 2 run |
| sample_stb | input | 1 | One pulse per PWM period; samples valid with it |
| ph_a | input | SAMPLE_W | Terminal A sample, unsigned |
| ph_b | input | SAMPLE_W | Terminal B sample, unsigned |
| ph_c | input | SAMPLE_W | Terminal C sample, unsigned |
| comm_state | output | 3 | Commutation step, R=0 .. F=6 |
| freq_word | output | FREQ_W | Oscillator control word |
| step_pulse | output | 1 | One-cycle pulse per accumulator carry |
| tach | output | 1 | Square-wave speed output |

## Verification
The assertions assume that mode changes only between clock edges. They also assume FREQ_W is smaller than ACC_W, so that two carries can never fall on back-to-back cycles. The bench drives every input on the falling edge and uses FREQ_W = 12 and ACC_W = 16. It applies a strobe only when step_pulse is low, so the step the strobe is judged against is the step visible on comm_state.

// File: rtl/bemf_pkg.sv
package bemf_pkg;

    typedef enum logic [2:0] {
        ST_R = 3'd0,
        ST_A = 3'd1,
        ST_B = 3'd2,
        ST_C = 3'd3,
        ST_D = 3'd4,
        ST_E = 3'd5,
        ST_F = 3'd6
    } comm_t;

    localparam logic [1:0] MD_RAMP = 2'd1;
    localparam logic [1:0] MD_RUN  = 2'd2;

endpackage

// File: rtl/bemf_phase_det.sv
module bemf_phase_det
    import bemf_pkg::*;
#(
    parameter int SAMPLE_W = 10,
    localparam int ERR_W   = SAMPLE_W + 2
) (
    input  comm_t                      state,
    input  logic                       enable,
    input  logic [SAMPLE_W-1:0]        ph_a,
    input  logic [SAMPLE_W-1:0]        ph_b,
    input  logic [SAMPLE_W-1:0]        ph_c,
    output logic signed [ERR_W-1:0]    err
);

    logic [ERR_W-1:0]        sum3;
    logic [ERR_W-1:0]        star;
    logic [SAMPLE_W-1:0]     floating;
    logic                    invert;
    logic signed [ERR_W-1:0] diff;

    // Virtual star point from the three terminal samples
    always_comb begin
        sum3 = ERR_W'(ph_a) + ERR_W'(ph_b) + ERR_W'(ph_c);
        star = sum3 / ERR_W'(3);
    end

    // Floating terminal and the sign correction for each step
    always_comb begin
        unique case (state)
            ST_A:    begin floating = ph_b; invert = 1'b0; end
            ST_B:    begin floating = ph_a; invert = 1'b1; end
            ST_C:    begin floating = ph_c; invert = 1'b0; end
            ST_D:    begin floating = ph_b; invert = 1'b1; end
            ST_E:    begin floating = ph_a; invert = 1'b0; end
            ST_F:    begin floating = ph_c; invert = 1'b1; end
            default: begin floating = '0;   invert = 1'b0; end
        endcase
    end

    always_comb begin
        diff = $signed({2'b00, floating}) - $signed(star);
        if (!enable || state == ST_R)
            err = '0;
        else if (invert)
            err = -diff;
        else
            err = diff;
    end

endmodule

// File: rtl/bemf_loop_filter.sv
module bemf_loop_filter #(
    parameter int ERR_W     = 12,
    parameter int FREQ_W    = 16,
    parameter int KP_SH     = 4,
    parameter int KI_SH     = 0,
    parameter int RAMP_STEP = 256,
    localparam int WIDE     = FREQ_W + ERR_W + KP_SH + KI_SH + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     ramp,
    input  logic                     run,
    input  logic                     stb,
    input  logic signed [ERR_W-1:0]  err,
    output logic [FREQ_W-1:0]        freq_word
);

    localparam logic [FREQ_W-1:0]      WORD_MAX = '1;
    localparam logic signed [WIDE-1:0] MAX_X    = $signed({{(WIDE-FREQ_W){1'b0}}, WORD_MAX});
    localparam logic signed [WIDE-1:0] STEP_X   = WIDE'(RAMP_STEP);

    function automatic logic [FREQ_W-1:0] clamp(input logic signed [WIDE-1:0] v);
        if (v[WIDE-1])
            return '0;
        if (v > MAX_X)
            return WORD_MAX;
        return v[FREQ_W-1:0];
    endfunction

    logic [FREQ_W-1:0]      integ;
    logic signed [WIDE-1:0] err_x;
    logic signed [WIDE-1:0] integ_x;
    logic signed [WIDE-1:0] inew_x;
    logic [FREQ_W-1:0]      integ_run;
    logic [FREQ_W-1:0]      freq_run;
    logic [FREQ_W-1:0]      integ_ramp;

    always_comb begin
        err_x      = {{(WIDE-ERR_W){err[ERR_W-1]}}, err};
        integ_x    = $signed({{(WIDE-FREQ_W){1'b0}}, integ});
        integ_run  = clamp(integ_x + (err_x <<< KI_SH));
        inew_x     = $signed({{(WIDE-FREQ_W){1'b0}}, integ_run});
        freq_run   = clamp(inew_x + (err_x <<< KP_SH));
        integ_ramp = clamp(integ_x + STEP_X);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            integ     <= '0;
            freq_word <= '0;
        end else if (clear) begin
            integ     <= '0;
            freq_word <= '0;
        end else if (stb && ramp) begin
            integ     <= integ_ramp;
            freq_word <= integ_ramp;
        end else if (stb && run) begin
            integ     <= integ_run;
            freq_word <= freq_run;
        end
    end

endmodule

// File: rtl/bemf_nco.sv
module bemf_nco #(
    parameter int FREQ_W = 16,
    parameter int ACC_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [FREQ_W-1:0] freq_word,
    output logic              step,
    output logic              tach
);

    logic [ACC_W-1:0] acc;
    logic [ACC_W:0]   acc_sum;

    always_comb acc_sum = {1'b0, acc} + {{(ACC_W+1-FREQ_W){1'b0}}, freq_word};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc  <= '0;
            step <= 1'b0;
        end else if (clear) begin
            acc  <= '0;
            step <= 1'b0;
        end else begin
            acc  <= acc_sum[ACC_W-1:0];
            step <= acc_sum[ACC_W];
        end
    end

    assign tach = acc[ACC_W-1];

endmodule

// File: rtl/bemf_pll.sv
module bemf_pll
    import bemf_pkg::*;
#(
    parameter int SAMPLE_W  = 10,
    parameter int FREQ_W    = 16,
    parameter int ACC_W     = 24,
    parameter int KP_SH     = 4,
    parameter int KI_SH     = 0,
    parameter int RAMP_STEP = 256,
    localparam int ERR_W    = SAMPLE_W + 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          mode,
    input  logic                sample_stb,
    input  logic [SAMPLE_W-1:0] ph_a,
    input  logic [SAMPLE_W-1:0] ph_b,
    input  logic [SAMPLE_W-1:0] ph_c,
    output logic [2:0]          comm_state,
    output logic [FREQ_W-1:0]   freq_word,
    output logic                step_pulse,
    output logic                tach
);

    comm_t                   state_q;
    comm_t                   state_d;
    logic                    in_ramp;
    logic                    in_run;
    logic                    in_align;
    logic signed [ERR_W-1:0] pd_err;

    assign in_ramp  = (mode == MD_RAMP);
    assign in_run   = (mode == MD_RUN);
    assign in_align = !(in_ramp || in_run);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_R;
        else
            state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        if (in_align) begin
            state_d = ST_R;
        end else if (step_pulse) begin
            unique case (state_q)
                ST_R:    state_d = ST_A;
                ST_A:    state_d = ST_B;
                ST_B:    state_d = ST_C;
                ST_C:    state_d = ST_D;
                ST_D:    state_d = ST_E;
                ST_E:    state_d = ST_F;
                ST_F:    state_d = ST_A;
                default: state_d = ST_R;
            endcase
        end
    end

    // Outputs
    always_comb comm_state = state_q;

    bemf_phase_det #(
        .SAMPLE_W (SAMPLE_W)
    ) i_phase_det (
        .state  (state_q),
        .enable (in_run),
        .ph_a   (ph_a),
        .ph_b   (ph_b),
        .ph_c   (ph_c),
        .err    (pd_err)
    );

    bemf_loop_filter #(
        .ERR_W     (ERR_W),
        .FREQ_W    (FREQ_W),
        .KP_SH     (KP_SH),
        .KI_SH     (KI_SH),
        .RAMP_STEP (RAMP_STEP)
    ) i_loop_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (in_align),
        .ramp      (in_ramp),
        .run       (in_run),
        .stb       (sample_stb),
        .err       (pd_err),
        .freq_word (freq_word)
    );

    bemf_nco #(
        .FREQ_W (FREQ_W),
        .ACC_W  (ACC_W)
    ) i_nco (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (in_align),
        .freq_word (freq_word),
        .step      (step_pulse),
        .tach      (tach)
    );

endmodule

// File: rtl/bemf_pll_chk.sv
module bemf_pll_chk #(
    parameter int FREQ_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode,
    input logic              sample_stb,
    input logic [2:0]        comm_state,
    input logic [FREQ_W-1:0] freq_word,
    input logic              step_pulse,
    input logic              tach
);

    function automatic logic [2:0] succ(input logic [2:0] s);
        return (s == 3'd0 || s == 3'd6) ? 3'd1 : s + 3'd1;
    endfunction

    logic active;
    assign active = (mode == 2'd1) || (mode == 2'd2);

    // R2: align clears the machine and the oscillator
    a_r2_align_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (comm_state == 3'd0 && freq_word == '0 && !step_pulse && !tach));

    // R12: word only moves on a strobe
    a_r12_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !sample_stb) |=> $stable(freq_word));

    // R9: carries never on back-to-back cycles
    a_r9_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        step_pulse |=> !step_pulse);

    // R10: step pulse advances in order
    a_r10_order: assert property (@(posedge clk) disable iff (!rst_n)
        (active && step_pulse) |=> comm_state == succ($past(comm_state)));

    // R10: no step pulse, no change
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !step_pulse) |=> $stable(comm_state));

endmodule

bind bemf_pll bemf_pll_chk #(.FREQ_W(FREQ_W)) i_bemf_pll_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .sample_stb (sample_stb),
    .comm_state (comm_state),
    .freq_word  (freq_word),
    .step_pulse (step_pulse),
    .tach       (tach)
);

// File: tb/test_bemf_pll.sv
module test_bemf_pll;

    localparam int CLK_PERIOD = 10;
    localparam int SAMPLE_W   = 10;
    localparam int FREQ_W     = 12;
    localparam int ACC_W      = 16;
    localparam int KP_SH      = 2;
    localparam int KI_SH      = 0;
    localparam int RAMP_STEP  = 64;
    localparam int WMAX       = (1 << FREQ_W) - 1;
    localparam int NVEC       = 8;

    // {state, ph_a, ph_b, ph_c}
    localparam logic [32:0] VEC [NVEC] = '{
        {3'd1, 10'd300, 10'd330, 10'd300},
        {3'd2, 10'd280, 10'd300, 10'd300},
        {3'd3, 10'd300, 10'd300, 10'd290},
        {3'd4, 10'd300, 10'd320, 10'd300},
        {3'd5, 10'd310, 10'd300, 10'd300},
        {3'd6, 10'd300, 10'd300, 10'd340},
        {3'd1, 10'd500, 10'd400, 10'd100},
        {3'd4, 10'd0,   10'd0,   10'd2}
    };

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [1:0]          mode = 2'd0;
    logic                sample_stb = 1'b0;
    logic [SAMPLE_W-1:0] ph_a = '0;
    logic [SAMPLE_W-1:0] ph_b = '0;
    logic [SAMPLE_W-1:0] ph_c = '0;
    logic [2:0]          comm_state;
    logic [FREQ_W-1:0]   freq_word;
    logic                step_pulse;
    logic                tach;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bemf_pll #(
        .SAMPLE_W (SAMPLE_W), .FREQ_W (FREQ_W), .ACC_W (ACC_W),
        .KP_SH (KP_SH), .KI_SH (KI_SH), .RAMP_STEP (RAMP_STEP)
    ) i_bemf_pll (
        .clk (clk), .rst_n (rst_n), .mode (mode), .sample_stb (sample_stb),
        .ph_a (ph_a), .ph_b (ph_b), .ph_c (ph_c),
        .comm_state (comm_state), .freq_word (freq_word),
        .step_pulse (step_pulse), .tach (tach)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int model_err(input int st, input int a, input int b, input int c);
        int star = (a + b + c) / 3;
        int fl = (st == 1 || st == 4) ? b : (st == 2 || st == 5) ? a : c;
        int d = fl - star;
        return (st == 2 || st == 4 || st == 6) ? -d : d;
    endfunction

    function automatic int sat(input int v);
        return (v < 0) ? 0 : (v > WMAX) ? WMAX : v;
    endfunction

    // Called at a falling edge: strobe for one cycle, return at the next falling edge
    task automatic strobe_now(input int a, input int b, input int c);
        ph_a = SAMPLE_W'(a); ph_b = SAMPLE_W'(b); ph_c = SAMPLE_W'(c);
        sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0;
    endtask

    task automatic wait_quiet();
        @(negedge clk);
        while (step_pulse) @(negedge clk);
    endtask

    task automatic wait_state(input int st);
        @(negedge clk);
        while (!(comm_state == 3'(st) && !step_pulse)) @(negedge clk);
    endtask

    // Drive a full-scale pattern whose corrected error has the wanted sign
    task automatic push(input bit up);
        int st;
        bit high;
        int hi, lo;
        wait_quiet();
        st = int'(comm_state);
        high = ((st == 2 || st == 4 || st == 6) ? 1'b1 : 1'b0) ^ up;
        hi = high ? 1023 : 0;
        lo = high ? 0 : 1023;
        if (st == 1 || st == 4)      strobe_now(lo, hi, lo);
        else if (st == 2 || st == 5) strobe_now(hi, lo, lo);
        else                         strobe_now(lo, lo, hi);
    endtask

    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog all-requirements actual=%0d expected=%0d", cyc, 150000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int base;
        int steps;
        int highs;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 comm_state", int'(comm_state), 0);
        check("R1 freq_word", int'(freq_word), 0);
        check("R1 step_pulse", int'(step_pulse), 0);
        check("R1 tach", int'(tach), 0);
        rst_n = 1'b1;

        // R2: align ignores strobes
        mode = 2'd0;
        @(negedge clk);
        strobe_now(1023, 0, 0);
        check("R2 align freq_word", int'(freq_word), 0);
        check("R2 align comm_state", int'(comm_state), 0);

        // R3: ramp adds a fixed step and ignores samples
        mode = 2'd1;
        @(negedge clk);
        for (int k = 1; k <= 8; k++) begin
            strobe_now((k * 131) % 1024, (k * 517) % 1024, k * 7);
            check("R3 ramp freq_word", int'(freq_word), k * RAMP_STEP);
        end
        check("R10 still rest before first step", int'(comm_state), 0);

        // R10: first step leaves rest for A
        @(negedge clk);
        while (!step_pulse) @(negedge clk);
        check("R10 rest during step pulse", int'(comm_state), 0);
        @(negedge clk);
        check("R10 rest to A", int'(comm_state), 1);

        // R9 R11: rate and tach duty at word 512
        mode = 2'd2;
        steps = 0;
        highs = 0;
        for (int k = 0; k < 1024; k++) begin
            @(negedge clk);
            steps += int'(step_pulse);
            highs += int'(tach);
        end
        check("R9 steps in 1024 cycles", steps, 8);
        check("R11 tach high cycles", highs, 512);
        check("R12 word held without strobe", int'(freq_word), 512);

        // R4 R5 R6 R7: vector walk in run mode
        base = 512;
        for (int i = 0; i < NVEC; i++) begin
            automatic int st = int'(VEC[i][32:30]);
            automatic int a  = int'(VEC[i][29:20]);
            automatic int b  = int'(VEC[i][19:10]);
            automatic int c  = int'(VEC[i][9:0]);
            automatic int e  = model_err(st, a, b, c);
            automatic int ni = sat(base + e * (1 << KI_SH));
            wait_state(st);
            strobe_now(a, b, c);
            check($sformatf("R4 R5 R6 R7 vec%0d word", i), int'(freq_word),
                  sat(ni + e * (1 << KP_SH)));
            strobe_now(300, 300, 300);
            check($sformatf("R7 vec%0d integrator", i), int'(freq_word), ni);
            base = ni;
        end

        // R8: saturation at both ends
        for (int k = 0; k < 6; k++) push(1'b1);
        check("R8 saturate high", int'(freq_word), WMAX);
        for (int k = 0; k < 10; k++) push(1'b0);
        @(negedge clk);
        strobe_now(300, 300, 300);
        check("R8 saturate low", int'(freq_word), 0);
        push(1'b0);
        check("R8 stays at zero", int'(freq_word), 0);

        // R9: zero word gives no steps
        steps = 0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            steps += int'(step_pulse);
        end
        check("R9 no steps at zero word", steps, 0);

        // R2: mode 3 acts as align
        mode = 2'd3;
        @(negedge clk);
        @(negedge clk);
        check("R2 mode3 comm_state", int'(comm_state), 0);
        check("R2 mode3 freq_word", int'(freq_word), 0);
        check("R2 mode3 tach", int'(tach), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule